// File: doc/BRIEF.md
# Storage Protection Key Checker

This block guards main memory by checking every access against a small table of partition keys. The address space is split into sixteen equal partitions. Each partition holds a 4-bit key, and the running program holds a 4-bit access key in its status word. An access is granted when the two keys agree, or when the program runs with the all-zero master key, which opens every partition.

The grant answer is combinational, so the memory pipeline can gate the access in the same cycle it is requested. A protection fault is raised through a flop for the cycle after a denied request. It stays up until the next request arrives. The key table is loaded through a dedicated write port. That port takes effect only while the processor is in supervisor mode. A load attempted from user mode is discarded and flagged as a one-cycle fault.

Top module: `stor_key_guard`

## Requirements
- R1: The partition index is the top 4 bits of the access address (bits 15:12 with the default 16-bit address), so partition n covers addresses n*4096 to n*4096+4095.
- R2: With acc_req high, acc_grant is high in the same cycle when psw_key equals the key stored for the addressed partition.
- R3: With acc_req high and psw_key equal to 0, acc_grant is high for every partition, whatever key that partition stores.
- R4: acc_grant is low whenever acc_req is low, and low for a request whose nonzero psw_key differs from the stored partition key.
- R5: prot_fault is registered. After a clock edge with acc_req high, it is high if that request was denied and low if it was granted (barring R7). In cycles without a request, the access part of the fault keeps its value.
- R6: With tbl_we high and sup_mode high, tbl_key is stored into the entry selected by tbl_idx at the clock edge. A request in that same cycle is still checked against the old key.
- R7: With tbl_we high and sup_mode low, the table is left unchanged and prot_fault is high for exactly the one cycle after that edge (ORed with any held access fault).
- R8: Reset (rst_n low, active-low, synchronous) clears every partition key to 0 and clears prot_fault.
- R9: acc_write (1 = write, 0 = read) has no effect on the check. Reads and writes are granted or denied alike.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_req | input | 1 | Memory access request in this cycle |
| acc_write | input | 1 | Access direction, 1 = write, 0 = read |
| acc_addr | input | 16 | Access address |
| psw_key | input | 4 | Access key from the status word |
| sup_mode | input | 1 | Processor is in supervisor mode |
| tbl_we | input | 1 | Key table write strobe |
| tbl_idx | input | 4 | Partition whose key is written |
| tbl_key | input | 4 | Key value to write |
| acc_grant | output | 1 | Access allowed (combinational) |
| prot_fault | output | 1 | Registered protection fault |

## Verification
acc_grant has no register in its path. It is therefore sampled 2 ns after the inputs change at the falling edge, well before the next rising edge. prot_fault and every table update take effect one rising edge after their stimulus. Each fault check is sampled 2 ns after that edge, before the next inputs are driven. The one-cycle fault pulse from a rejected user-mode load is checked over two consecutive edges: high after the first, low after the second. Same-cycle write-and-access cases confirm that the new key is seen only from the following cycle.

// File: rtl/skg_pkg.sv
package skg_pkg;

    // Two separate fault sources, kept apart so each follows its own lifetime
    typedef struct packed {
        logic acc_fault;   // last request denied, held until next request
        logic wr_fault;    // rejected table load, lasts one cycle
    } skg_fault_t;

endpackage

// File: rtl/skg_part_decode.sv
module skg_part_decode #(
    parameter int ADDR_W = 16,
    parameter int PART_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [PART_W-1:0] part_idx
);

    // Fixed-size partitions: the high address bits select the partition
    assign part_idx = addr[ADDR_W-1 -: PART_W];

endmodule

// File: rtl/skg_key_table.sv
module skg_key_table #(
    parameter int KEY_W  = 4,
    parameter int PART_W = 4,
    localparam int PART_CNT = 1 << PART_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PART_W-1:0] wr_idx,
    input  logic [KEY_W-1:0]  wr_key,
    input  logic [PART_W-1:0] rd_idx,
    output logic [KEY_W-1:0]  rd_key
);

    logic [KEY_W-1:0] key_d [PART_CNT];
    logic [KEY_W-1:0] key_q [PART_CNT];

    always_comb begin
        for (int i = 0; i < PART_CNT; i++) begin
            key_d[i] = key_q[i];
        end
        if (wr_en) begin
            key_d[wr_idx] = wr_key;
        end
    end

    for (genvar g = 0; g < PART_CNT; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                key_q[g] <= '0;
            end else begin
                key_q[g] <= key_d[g];
            end
        end
    end

    // Read returns the registered key: a same-cycle write is not visible
    assign rd_key = key_q[rd_idx];

endmodule

// File: rtl/skg_key_match.sv
module skg_key_match #(
    parameter int KEY_W = 4
) (
    input  logic             req,
    input  logic [KEY_W-1:0] psw_key,
    input  logic [KEY_W-1:0] part_key,
    output logic             grant
);

    logic master_key;
    logic keys_equal;

    always_comb begin
        master_key = (psw_key == '0);
        keys_equal = (psw_key == part_key);
        grant      = req && (master_key || keys_equal);
    end

endmodule

// File: rtl/stor_key_guard.sv
module stor_key_guard #(
    parameter int ADDR_W = 16,
    parameter int KEY_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_req,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [KEY_W-1:0]  psw_key,
    input  logic              sup_mode,
    input  logic              tbl_we,
    input  logic [KEY_W-1:0]  tbl_idx,
    input  logic [KEY_W-1:0]  tbl_key,
    output logic              acc_grant,
    output logic              prot_fault
);

    import skg_pkg::*;

    // One partition per key value
    localparam int PART_W = KEY_W;

    logic [PART_W-1:0] part_idx;
    logic [KEY_W-1:0]  part_key;
    logic              load_ok;
    logic              load_bad;
    logic              grant_w;
    logic              unused_dir;

    skg_fault_t flt_d;
    skg_fault_t flt_q;

    // The check is the same for both directions
    assign unused_dir = acc_write;

    assign load_ok  = tbl_we &&  sup_mode;
    assign load_bad = tbl_we && !sup_mode;

    skg_part_decode #(
        .ADDR_W (ADDR_W),
        .PART_W (PART_W)
    ) decode_i (
        .addr     (acc_addr),
        .part_idx (part_idx)
    );

    skg_key_table #(
        .KEY_W  (KEY_W),
        .PART_W (PART_W)
    ) table_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (load_ok),
        .wr_idx (tbl_idx),
        .wr_key (tbl_key),
        .rd_idx (part_idx),
        .rd_key (part_key)
    );

    skg_key_match #(
        .KEY_W (KEY_W)
    ) match_i (
        .req      (acc_req),
        .psw_key  (psw_key),
        .part_key (part_key),
        .grant    (grant_w)
    );

    always_comb begin
        flt_d          = flt_q;
        flt_d.wr_fault = load_bad;
        if (acc_req) begin
            flt_d.acc_fault = !grant_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_q <= '0;
        end else begin
            flt_q <= flt_d;
        end
    end

    assign acc_grant  = grant_w;
    assign prot_fault = flt_q.acc_fault || flt_q.wr_fault;

endmodule

// File: rtl/skg_guard_chk.sv
module skg_guard_chk #(
    parameter int ADDR_W = 16,
    parameter int KEY_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_req,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [KEY_W-1:0]  psw_key,
    input logic              sup_mode,
    input logic              tbl_we,
    input logic [KEY_W-1:0]  tbl_idx,
    input logic [KEY_W-1:0]  tbl_key,
    input logic              acc_grant,
    input logic              prot_fault
);

    // R4: no grant without a request
    assert_grant_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_req |-> !acc_grant);

    // R3: master key opens every partition
    assert_master_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && psw_key == '0) |-> acc_grant);

    // R5: a denied request faults in the next cycle
    assert_denied_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !acc_grant) |=> prot_fault);

    // R5: a granted request with no rejected load clears the fault
    assert_granted_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_grant && !(tbl_we && !sup_mode)) |=> !prot_fault);

    // R7: a user-mode table load faults in the next cycle
    assert_user_load_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_we && !sup_mode) |=> prot_fault);

    // R6: a supervisor load is in force from the following cycle
    assert_load_takes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tbl_we && sup_mode) && acc_req
         && acc_addr[ADDR_W-1 -: KEY_W] == $past(tbl_idx)
         && psw_key == $past(tbl_key)) |-> acc_grant);

endmodule

bind stor_key_guard skg_guard_chk #(
    .ADDR_W (ADDR_W),
    .KEY_W  (KEY_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_req    (acc_req),
    .acc_addr   (acc_addr),
    .psw_key    (psw_key),
    .sup_mode   (sup_mode),
    .tbl_we     (tbl_we),
    .tbl_idx    (tbl_idx),
    .tbl_key    (tbl_key),
    .acc_grant  (acc_grant),
    .prot_fault (prot_fault)
);

// File: tb/stor_key_guard_tb_top.sv
module stor_key_guard_tb_top;

    localparam int CLK_PERIOD = 20;   // 50 MHz

    typedef struct packed {
        logic        req;
        logic        wr;
        logic [15:0] addr;
        logic [3:0]  pkey;
        logic        sup;
        logic        we;
        logic [3:0]  idx;
        logic [3:0]  key;
        logic        exp_grant;
        logic        exp_fault;
        logic [3:0]  rq;
    } vec_t;

    localparam int NVEC = 18;

    // req wr addr pkey sup we idx key grant fault rq
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 1'b0, 16'h1234, 4'h0, 1'b0, 1'b0, 4'h0, 4'h0, 1'b1, 1'b0, 4'd3}, // R3 master key, R8 fresh table
        '{1'b1, 1'b0, 16'h1234, 4'h5, 1'b0, 1'b0, 4'h0, 4'h0, 1'b0, 1'b1, 4'd8}, // R8 keys are zero after reset
        '{1'b0, 1'b0, 16'h1234, 4'h0, 1'b0, 1'b0, 4'h0, 4'h0, 1'b0, 1'b1, 4'd4}, // R4 no req, R5 hold
        '{1'b0, 1'b0, 16'h0000, 4'h0, 1'b1, 1'b1, 4'h1, 4'h5, 1'b0, 1'b1, 4'd6}, // R6 supervisor load
        '{1'b1, 1'b1, 16'h1ABC, 4'h5, 1'b0, 1'b0, 4'h0, 4'h0, 1'b1, 1'b0, 4'd2}, // R2 match, write
        '{1'b1, 1'b0, 16'h1ABC, 4'h5, 1'b0, 1'b0, 4'h0, 4'h0, 1'b1, 1'b0, 4'd9}, // R9 read same as write
        '{1'b1, 1'b1, 16'h2000, 4'h5, 1'b0, 1'b0, 4'h0, 4'h0, 1'b0, 1'b1, 4'd4}, // R4 mismatch
        '{1'b0, 1'b0, 16'h0000, 4'h0, 1'b0, 1'b1, 4'h2, 4'h5, 1'b0, 1'b1, 4'd7}, // R7 user load rejected
        '{1'b1, 1'b0, 16'h2000, 4'h5, 1'b0, 1'b0, 4'h0, 4'h0, 1'b0, 1'b1, 4'd7}, // R7 table unchanged
        '{1'b1, 1'b0, 16'h1000, 4'h0, 1'b0, 1'b0, 4'h0, 4'h0, 1'b1, 1'b0, 4'd3}, // R3 master key
        '{1'b0, 1'b0, 16'h0000, 4'h0, 1'b0, 1'b0, 4'h0, 4'h0, 1'b0, 1'b0, 4'd5}, // R5 idle, no fault
        '{1'b0, 1'b0, 16'h0000, 4'h0, 1'b0, 1'b1, 4'h3, 4'h7, 1'b0, 1'b1, 4'd7}, // R7 pulse high
        '{1'b0, 1'b0, 16'h0000, 4'h0, 1'b0, 1'b0, 4'h0, 4'h0, 1'b0, 1'b0, 4'd7}, // R7 pulse ends
        '{1'b1, 1'b0, 16'hF000, 4'h9, 1'b1, 1'b1, 4'hF, 4'h9, 1'b0, 1'b1, 4'd6}, // R6 same-cycle sees old key
        '{1'b1, 1'b0, 16'hFFFF, 4'h9, 1'b0, 1'b0, 4'h0, 4'h0, 1'b1, 1'b0, 4'd1}, // R1 top of partition 15
        '{1'b1, 1'b0, 16'hEFFF, 4'h9, 1'b0, 1'b0, 4'h0, 4'h0, 1'b0, 1'b1, 4'd1}, // R1 top of partition 14
        '{1'b1, 1'b1, 16'h0FFF, 4'h3, 1'b0, 1'b0, 4'h0, 4'h0, 1'b0, 1'b1, 4'd4}, // R4 partition 0 mismatch
        '{1'b0, 1'b0, 16'h0000, 4'h0, 1'b0, 1'b0, 4'h0, 4'h0, 1'b0, 1'b1, 4'd5}  // R5 hold
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_req = 1'b0;
    logic        acc_write = 1'b0;
    logic [15:0] acc_addr = '0;
    logic [3:0]  psw_key = '0;
    logic        sup_mode = 1'b0;
    logic        tbl_we = 1'b0;
    logic [3:0]  tbl_idx = '0;
    logic [3:0]  tbl_key = '0;
    logic        acc_grant;
    logic        prot_fault;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    stor_key_guard dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_req    (acc_req),
        .acc_write  (acc_write),
        .acc_addr   (acc_addr),
        .psw_key    (psw_key),
        .sup_mode   (sup_mode),
        .tbl_we     (tbl_we),
        .tbl_idx    (tbl_idx),
        .tbl_key    (tbl_key),
        .acc_grant  (acc_grant),
        .prot_fault (prot_fault)
    );

    task automatic check(input string rq, input string what, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b", rq, what, act, exp);
        end
    endtask

    // Drive at the falling edge, check grant before the rising edge,
    // check the registered fault just after it
    task automatic apply(input vec_t v, input int n);
        string rq;
        rq = $sformatf("R%0d (step %0d)", v.rq, n);
        @(negedge clk);
        acc_req   = v.req;
        acc_write = v.wr;
        acc_addr  = v.addr;
        psw_key   = v.pkey;
        sup_mode  = v.sup;
        tbl_we    = v.we;
        tbl_idx   = v.idx;
        tbl_key   = v.key;
        #2;
        check(rq, "acc_grant", acc_grant, v.exp_grant);
        @(posedge clk);
        #2;
        check(rq, "prot_fault", prot_fault, v.exp_fault);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R8", "prot_fault after reset", prot_fault, 1'b0);
        check("R4", "acc_grant idle in reset", acc_grant, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i], i);
        end

        // R8: load a key, then reset mid-run with a fault held
        apply('{1'b0, 1'b0, 16'h0000, 4'h0, 1'b1, 1'b1, 4'h1, 4'h5, 1'b0, 1'b1, 4'd8}, 100);
        apply('{1'b1, 1'b0, 16'h1000, 4'h5, 1'b0, 1'b0, 4'h0, 4'h0, 1'b1, 1'b0, 4'd2}, 101);
        apply('{1'b1, 1'b0, 16'h3000, 4'h5, 1'b0, 1'b0, 4'h0, 4'h0, 1'b0, 1'b1, 4'd4}, 102);
        @(negedge clk);
        rst_n   = 1'b0;
        acc_req = 1'b0;
        tbl_we  = 1'b0;
        @(posedge clk);
        #2;
        check("R8", "prot_fault cleared by reset", prot_fault, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        apply('{1'b1, 1'b0, 16'h1000, 4'h5, 1'b0, 1'b0, 4'h0, 4'h0, 1'b0, 1'b1, 4'd8}, 103);

        // R7 combined with a held access fault: fault stays high after the pulse
        apply('{1'b0, 1'b0, 16'h0000, 4'h0, 1'b0, 1'b1, 4'h1, 4'h5, 1'b0, 1'b1, 4'd7}, 104);
        apply('{1'b0, 1'b0, 16'h0000, 4'h0, 1'b0, 1'b0, 4'h0, 4'h0, 1'b0, 1'b1, 4'd5}, 105);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule